// File: doc/BRIEF.md
# Link Power and Operating-Mode Controller

This controller sits in the control plane of a serial video link repeater. Every system clock it decides which of five conditions the link path is in: powered down, waiting in standby for an input clock, passing data through as a linear redriver, acquiring lock as a retimer, or running as a locked retimer. From that condition it drives the enables for the clock-recovery/retiming path, the output drivers (active or high impedance) and the line terminations. It also produces the upstream hot-plug signal, gates the input polarity swap, and raises two status flags.

Power-down has three independent causes. Any one of them is enough: the output-enable input is low, a forced power-down control bit is set, or sink hot-plug is low while automatic hot-plug power-down is still allowed. A registered data-rate code is compared with a crossover threshold that has a hysteresis band. A two-bit mode field then picks forced redriver, automatic crossover, or forced retimer. The mode field is captured only while the link is powered down. When output-enable comes back after a long enough low time, the controller emits a one-cycle pulse that tells the register file to return to its defaults. All time intervals are parameters counted in system-clock cycles.

Top module: `lpm_ctrl`

## Requirements
- R1: While `oe_i` is low, or `cfg_pd_force_i` is 1, or `hpd_snk_i` is low with `cfg_hpd_apd_dis_i` at 0, the controller is powered down from the next clock edge on. In that state `sts_pd_o`=1 and `cdr_en_o`, `drv_en_o` and `term_en_o` are all 0. When `cfg_hpd_apd_dis_i` is 1, a low `hpd_snk_i` causes no power-down.
- R2: With no power-down cause, `cfg_sigdet_en_i`=1 and `clk_valid_i`=0, the controller enters standby on the next edge. In standby `sts_stby_o`=1 and clock recovery, drivers and terminations are all 0. With `cfg_sigdet_en_i`=0, `clk_valid_i` is ignored and the path stays active.
- R3: The operating-mode code is read from `cfg_mode_i`. Code 00 selects redriver at every rate. Code 11 selects retimer at every rate. Code 01 selects automatic crossover. The reserved code 10 behaves as 01.
- R4: In automatic crossover, the rate counts as fast once the registered `rate_i` is at least RATE_THRESH+RATE_HYST. It counts as slow once `rate_i` is below RATE_THRESH-RATE_HYST. Between these limits the previous decision holds. A change at `rate_i` reaches the operating state on the third clock edge.
- R5: Every entry into retimer operation begins with acquisition. Acquisition lasts exactly ACQ_CYCLES clock cycles and has `cdr_en_o`=1. Locked retimer operation follows.
- R6: During acquisition, `drv_en_o` is 1 when `cfg_acq_quiet_i`=0 and 0 when `cfg_acq_quiet_i`=1. Terminations are on throughout.
- R7: `pol_swap_o` equals `cfg_pol_swap_i` during acquisition and locked retimer operation. In every other state it is 0, which includes a fallback to redriver.
- R8: `hpd_src_o` follows `hpd_snk_i` combinationally while `cfg_hpd_gate_i`=0. It is held at 0 while `cfg_hpd_gate_i`=1.
- R9: The mode code is captured only during clock cycles spent powered down. A change of `cfg_mode_i` at any other time has no effect until power-down has been passed through.
- R10: When `oe_i` rises after being low for at least OE_MIN_LOW sampled edges, `cfg_restore_o` pulses high for exactly one cycle, the cycle after the rising edge is sampled. A shorter low time gives no pulse.
- R11: During reset the controller is powered down (`sts_pd_o`=1, all enables 0) and the mode is automatic (01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_i | input | 1 | Output-enable input; low powers the path down |
| hpd_snk_i | input | 1 | Hot-plug level from the downstream sink |
| clk_valid_i | input | 1 | Input clock judged valid by the detector |
| rate_i | input | RATE_W | Measured data-rate code |
| cfg_pd_force_i | input | 1 | Forced power-down control bit |
| cfg_hpd_apd_dis_i | input | 1 | Disables power-down on low sink hot-plug |
| cfg_sigdet_en_i | input | 1 | Enables clock-detect standby |
| cfg_mode_i | input | 2 | Operating-mode code (00 redriver, 01 auto, 10 auto, 11 retimer) |
| cfg_acq_quiet_i | input | 1 | Holds drivers off during acquisition |
| cfg_pol_swap_i | input | 1 | Requested input polarity swap |
| cfg_hpd_gate_i | input | 1 | Holds upstream hot-plug deasserted |
| cdr_en_o | output | 1 | Clock-recovery / retiming path enable |
| drv_en_o | output | 1 | Output drivers active (0 = high-Z) |
| term_en_o | output | 1 | Line terminations enabled |
| hpd_src_o | output | 1 | Hot-plug level driven upstream |
| pol_swap_o | output | 1 | Polarity swap applied to the inputs |
| sts_pd_o | output | 1 | Status: powered down |
| sts_stby_o | output | 1 | Status: in clock-detect standby |
| cfg_restore_o | output | 1 | One-cycle request to return settings to defaults |

## Verification
The bench sets the rate code inside the hysteresis band, arriving from each side. A design without hysteresis, or one that compares against the bare threshold, would switch to the wrong mode there. Acquisition length is measured to the exact cycle with the quiet option on, so an off-by-one counter shows up as an early or late driver enable. The bench changes the mode code while the link is running and confirms nothing moves until a forced power-down pulse. It also drives a short and a long output-enable low time: a tracker that ignores the minimum or stretches its pulse would restore defaults wrongly. Each power-down cause is exercised on its own, including low hot-plug with the disable bit set, which must not power down.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_PWRDN  = 3'd0,
    ST_STBY   = 3'd1,
    ST_REDRV  = 3'd2,
    ST_ACQ    = 3'd3,
    ST_RETIME = 3'd4
  } lpm_state_e;

  localparam logic [1:0] MODE_FORCE_REDRV  = 2'b00;
  localparam logic [1:0] MODE_AUTO         = 2'b01;
  localparam logic [1:0] MODE_FORCE_RETIME = 2'b11;

  // Retimer wanted for a given mode code and rate decision.
  function automatic logic want_retime(input logic [1:0] mode, input logic fast);
    case (mode)
      MODE_FORCE_REDRV:  return 1'b0;
      MODE_FORCE_RETIME: return 1'b1;
      default:           return fast;  // automatic, reserved code acts the same
    endcase
  endfunction

  function automatic logic is_retimer(input lpm_state_e s);
    return (s == ST_ACQ) || (s == ST_RETIME);
  endfunction

  // Any of the three power-down causes.
  function automatic logic pd_cause(input logic oe, input logic force_pd,
                                    input logic hpd, input logic apd_dis);
    return !oe || force_pd || (!hpd && !apd_dis);
  endfunction

endpackage

// File: rtl/lpm_pwr_gate.sv
module lpm_pwr_gate #(
  parameter int OE_MIN_LOW = 2700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_i,
  input  logic hpd_snk_i,
  input  logic pd_force_i,
  input  logic apd_dis_i,
  output logic pd_req_o,
  output logic restore_o
);
  import lpm_pkg::*;

  localparam int CW = $clog2(OE_MIN_LOW + 1);
  localparam logic [CW-1:0] LOW_SAT = CW'(OE_MIN_LOW);

  logic          oe_q;
  logic [CW-1:0] low_cnt_q;
  logic          restore_q;
  logic          oe_rise;
  logic          low_long;

  assign pd_req_o = pd_cause(oe_i, pd_force_i, hpd_snk_i, apd_dis_i);
  assign oe_rise  = oe_i && !oe_q;
  assign low_long = (low_cnt_q == LOW_SAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q      <= 1'b0;
      low_cnt_q <= '0;
      restore_q <= 1'b0;
    end else begin
      oe_q      <= oe_i;
      restore_q <= oe_rise && low_long;
      if (oe_i)
        low_cnt_q <= '0;
      else if (!low_long)
        low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  assign restore_o = restore_q;

  assert_restore_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restore_q |=> !restore_q);

  assert_restore_after_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restore_q) |-> $past(!oe_q));

endmodule

// File: rtl/lpm_rate_class.sv
module lpm_rate_class #(
  parameter int RATE_W      = 8,
  parameter int RATE_THRESH = 100,
  parameter int RATE_HYST   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_i,
  output logic              fast_o
);
  localparam int HI = RATE_THRESH + RATE_HYST;
  localparam int LO = RATE_THRESH - RATE_HYST;
  localparam logic [RATE_W-1:0] HI_C = RATE_W'(HI);
  localparam logic [RATE_W-1:0] LO_C = RATE_W'(LO);

  logic [RATE_W-1:0] rate_q;
  logic              fast_q;

  function automatic logic next_fast(input logic cur, input logic [RATE_W-1:0] code);
    if (code >= HI_C)     return 1'b1;
    else if (code < LO_C) return 1'b0;
    else                  return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      fast_q <= 1'b0;
    end else begin
      rate_q <= rate_i;
      fast_q <= next_fast(fast_q, rate_q);
    end
  end

  assign fast_o = fast_q;

  assert_band_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rate_q < HI_C) && (rate_q >= LO_C)) |=> $stable(fast_q));

  assert_rise_needs_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_q) |-> $past(rate_q >= HI_C));

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm #(
  parameter int ACQ_CYCLES = 189000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_req_i,
  input  logic       sigdet_en_i,
  input  logic       clk_valid_i,
  input  logic       fast_i,
  input  logic [1:0] cfg_mode_i,
  input  logic       acq_quiet_i,
  input  logic       pol_req_i,
  output logic       cdr_en_o,
  output logic       drv_en_o,
  output logic       term_en_o,
  output logic       pol_swap_o,
  output logic       sts_pd_o,
  output logic       sts_stby_o
);
  import lpm_pkg::*;

  localparam int AW = $clog2(ACQ_CYCLES + 1);
  localparam logic [AW-1:0] ACQ_LAST = AW'(ACQ_CYCLES - 1);

  lpm_state_e st_q, st_d;
  logic [AW-1:0] acq_cnt_q;
  logic [1:0]    mode_q;
  logic          acq_done;
  logic          retime_wanted;
  logic          no_clock;

  assign acq_done      = (st_q == ST_ACQ) && (acq_cnt_q == ACQ_LAST);
  assign retime_wanted = want_retime(mode_q, fast_i);
  assign no_clock      = sigdet_en_i && !clk_valid_i;

  always_comb begin
    if (pd_req_i)
      st_d = ST_PWRDN;
    else if (no_clock)
      st_d = ST_STBY;
    else if (retime_wanted) begin
      if (st_q == ST_RETIME)   st_d = ST_RETIME;
      else if (acq_done)       st_d = ST_RETIME;
      else                     st_d = ST_ACQ;
    end else
      st_d = ST_REDRV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_PWRDN;
      acq_cnt_q <= '0;
      mode_q    <= MODE_AUTO;
    end else begin
      st_q <= st_d;
      if (st_q == ST_ACQ && !acq_done)
        acq_cnt_q <= acq_cnt_q + 1'b1;
      else
        acq_cnt_q <= '0;
      if (st_q == ST_PWRDN)
        mode_q <= cfg_mode_i;
    end
  end

  always_comb begin
    cdr_en_o   = 1'b0;
    drv_en_o   = 1'b0;
    term_en_o  = 1'b0;
    sts_pd_o   = 1'b0;
    sts_stby_o = 1'b0;
    case (st_q)
      ST_PWRDN: sts_pd_o = 1'b1;
      ST_STBY:  sts_stby_o = 1'b1;
      ST_REDRV: begin
        drv_en_o  = 1'b1;
        term_en_o = 1'b1;
      end
      ST_ACQ: begin
        cdr_en_o  = 1'b1;
        drv_en_o  = !acq_quiet_i;
        term_en_o = 1'b1;
      end
      ST_RETIME: begin
        cdr_en_o  = 1'b1;
        drv_en_o  = 1'b1;
        term_en_o = 1'b1;
      end
      default: sts_pd_o = 1'b1;
    endcase
  end

  assign pol_swap_o = pol_req_i && is_retimer(st_q);

  assert_pd_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req_i |=> sts_pd_o && !drv_en_o && !cdr_en_o);

  assert_stby_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_req_i && no_clock) |=> sts_stby_o && !cdr_en_o && !drv_en_o);

  assert_acq_before_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RETIME && $past(st_q) != ST_RETIME) |-> $past(st_q) == ST_ACQ);

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_PWRDN) |=> $stable(mode_q));

  assert_one_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sts_pd_o, sts_stby_o, cdr_en_o}));

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int RATE_W      = 8,
  parameter int RATE_THRESH = 100,
  parameter int RATE_HYST   = 4,
  parameter int ACQ_CYCLES  = 189000,
  parameter int OE_MIN_LOW  = 2700
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe_i,
  input  logic              hpd_snk_i,
  input  logic              clk_valid_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              cfg_pd_force_i,
  input  logic              cfg_hpd_apd_dis_i,
  input  logic              cfg_sigdet_en_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic              cfg_acq_quiet_i,
  input  logic              cfg_pol_swap_i,
  input  logic              cfg_hpd_gate_i,
  output logic              cdr_en_o,
  output logic              drv_en_o,
  output logic              term_en_o,
  output logic              hpd_src_o,
  output logic              pol_swap_o,
  output logic              sts_pd_o,
  output logic              sts_stby_o,
  output logic              cfg_restore_o
);

  logic pd_req;
  logic rate_fast;

  lpm_pwr_gate #(.OE_MIN_LOW(OE_MIN_LOW)) u_pwr (
    .clk        (clk),
    .rst_n      (rst_n),
    .oe_i       (oe_i),
    .hpd_snk_i  (hpd_snk_i),
    .pd_force_i (cfg_pd_force_i),
    .apd_dis_i  (cfg_hpd_apd_dis_i),
    .pd_req_o   (pd_req),
    .restore_o  (cfg_restore_o)
  );

  lpm_rate_class #(
    .RATE_W(RATE_W), .RATE_THRESH(RATE_THRESH), .RATE_HYST(RATE_HYST)
  ) u_rate (
    .clk    (clk),
    .rst_n  (rst_n),
    .rate_i (rate_i),
    .fast_o (rate_fast)
  );

  lpm_fsm #(.ACQ_CYCLES(ACQ_CYCLES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_req_i    (pd_req),
    .sigdet_en_i (cfg_sigdet_en_i),
    .clk_valid_i (clk_valid_i),
    .fast_i      (rate_fast),
    .cfg_mode_i  (cfg_mode_i),
    .acq_quiet_i (cfg_acq_quiet_i),
    .pol_req_i   (cfg_pol_swap_i),
    .cdr_en_o    (cdr_en_o),
    .drv_en_o    (drv_en_o),
    .term_en_o   (term_en_o),
    .pol_swap_o  (pol_swap_o),
    .sts_pd_o    (sts_pd_o),
    .sts_stby_o  (sts_stby_o)
  );

  assign hpd_src_o = hpd_snk_i && !cfg_hpd_gate_i;

  assert_pol_only_retimer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pol_swap_o |-> cdr_en_o);

  assert_drv_needs_term_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en_o |-> term_en_o);

endmodule

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ACQ  = 20;
  localparam int OEMIN = 8;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe = 1'b1, hpd = 1'b1, cval = 1'b1;
  logic [7:0] rate = 8'd50;
  logic pd_force = 1'b0, apd_dis = 1'b0, sigdet = 1'b0;
  logic [1:0] mode = 2'b01;
  logic quiet = 1'b1, pol = 1'b0, gate = 1'b0;
  logic cdr, drv, term, hsrc, pols, spd, sstby, rstr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_ctrl #(.RATE_W(8), .RATE_THRESH(100), .RATE_HYST(4),
             .ACQ_CYCLES(ACQ), .OE_MIN_LOW(OEMIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .oe_i(oe), .hpd_snk_i(hpd), .clk_valid_i(cval),
    .rate_i(rate), .cfg_pd_force_i(pd_force), .cfg_hpd_apd_dis_i(apd_dis),
    .cfg_sigdet_en_i(sigdet), .cfg_mode_i(mode), .cfg_acq_quiet_i(quiet),
    .cfg_pol_swap_i(pol), .cfg_hpd_gate_i(gate),
    .cdr_en_o(cdr), .drv_en_o(drv), .term_en_o(term), .hpd_src_o(hsrc),
    .pol_swap_o(pols), .sts_pd_o(spd), .sts_stby_o(sstby), .cfg_restore_o(rstr));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pd_pulse();
    pd_force = 1'b1; step(2); pd_force = 1'b0; step(1);
  endtask

  task automatic t_reset();
    step(3);
    chk("R11", "sts_pd in reset", spd, 1);
    chk("R11", "drv in reset", drv, 0);
    chk("R11", "cdr in reset", cdr, 0);
    rst_n = 1'b1;
    step(2);
    chk("R11", "auto mode slow -> redriver drv", drv, 1);
    chk("R11", "auto mode slow -> cdr off", cdr, 0);
    chk("R11", "term on", term, 1);
  endtask

  task automatic t_pd_causes();
    pd_force = 1'b1; step(1);
    chk("R1", "force pd sts", spd, 1);
    chk("R1", "force pd drv", drv, 0);
    chk("R1", "force pd term", term, 0);
    pd_force = 1'b0; step(1);
    chk("R1", "force released", spd, 0);
    hpd = 1'b0; step(1);
    chk("R1", "hpd low pd", spd, 1);
    apd_dis = 1'b1; step(1);
    chk("R1", "hpd low with disable no pd", spd, 0);
    chk("R1", "hpd low with disable drv", drv, 1);
    hpd = 1'b1; apd_dis = 1'b0; oe = 1'b0; step(1);
    chk("R1", "oe low pd", spd, 1);
    oe = 1'b1; step(1);
    chk("R1", "oe high resumes", drv, 1);
  endtask

  task automatic t_standby();
    sigdet = 1'b1; cval = 1'b0; step(1);
    chk("R2", "standby flag", sstby, 1);
    chk("R2", "standby drv off", drv, 0);
    chk("R2", "standby term off", term, 0);
    cval = 1'b1; step(1);
    chk("R2", "clock back flag", sstby, 0);
    chk("R2", "clock back drv", drv, 1);
    sigdet = 1'b0; cval = 1'b0; step(2);
    chk("R2", "detect off ignores clock", drv, 1);
    chk("R2", "detect off no standby", sstby, 0);
    cval = 1'b1;
  endtask

  task automatic t_crossover();
    quiet = 1'b1; rate = 8'd110; step(3);
    chk("R5", "acq start cdr", cdr, 1);
    chk("R6", "quiet acq drv off", drv, 0);
    chk("R6", "quiet acq term on", term, 1);
    step(ACQ - 1);
    chk("R5", "last acq cycle drv", drv, 0);
    step(1);
    chk("R5", "locked drv", drv, 1);
    chk("R5", "locked cdr", cdr, 1);
    rate = 8'd100; step(5);
    chk("R4", "band from fast holds", cdr, 1);
    rate = 8'd95; step(3);
    chk("R4", "below low limit redriver", cdr, 0);
    rate = 8'd103; step(5);
    chk("R4", "band from slow holds", cdr, 0);
    quiet = 1'b0; pol = 1'b1;
    rate = 8'd104; step(2);
    chk("R4", "not yet at 2 edges", cdr, 0);
    chk("R7", "redriver no swap", pols, 0);
    step(1);
    chk("R4", "high limit retimer", cdr, 1);
    chk("R6", "acq drivers active", drv, 1);
    chk("R7", "acq swap on", pols, 1);
    step(ACQ + 2);
    chk("R7", "locked swap on", pols, 1);
    rate = 8'd50; step(3);
    chk("R7", "fallback swap off", pols, 0);
    pol = 1'b0; quiet = 1'b1;
  endtask

  task automatic t_hpd();
    gate = 1'b0; hpd = 1'b1; step(1);
    chk("R8", "pass high", hsrc, 1);
    gate = 1'b1; #1;
    chk("R8", "gated", hsrc, 0);
    gate = 1'b0; apd_dis = 1'b1; hpd = 1'b0; #1;
    chk("R8", "pass low", hsrc, 0);
    hpd = 1'b1; apd_dis = 1'b0; step(1);
  endtask

  task automatic t_modes();
    rate = 8'd110; step(ACQ + 5);
    chk("R3", "auto fast locked", cdr, 1);
    mode = 2'b00; step(5);
    chk("R9", "mode change while running ignored", cdr, 1);
    pd_pulse(); step(1);
    chk("R3", "mode 00 redriver at fast rate", cdr, 0);
    chk("R3", "mode 00 drv", drv, 1);
    mode = 2'b11; rate = 8'd50; pd_pulse();
    chk("R3", "mode 11 acquires at slow rate", cdr, 1);
    step(ACQ + 1);
    chk("R3", "mode 11 locked", drv, 1);
    chk("R3", "mode 11 cdr", cdr, 1);
    mode = 2'b10; pd_pulse(); step(1);
    chk("R3", "mode 10 slow acts auto", cdr, 0);
    rate = 8'd110; step(3);
    chk("R3", "mode 10 fast acts auto", cdr, 1);
    mode = 2'b01; rate = 8'd50; pd_pulse();
  endtask

  task automatic t_restore();
    oe = 1'b0; step(3);
    oe = 1'b1; step(1);
    chk("R10", "short low no pulse", rstr, 0);
    step(1);
    chk("R10", "short low still none", rstr, 0);
    oe = 1'b0; step(OEMIN + 2);
    chk("R1", "oe low status", spd, 1);
    chk("R10", "no pulse while low", rstr, 0);
    oe = 1'b1; step(1);
    chk("R10", "long low pulse", rstr, 1);
    step(1);
    chk("R10", "pulse single cycle", rstr, 0);
  endtask

  initial begin
    t_reset();
    t_pd_causes();
    t_standby();
    t_crossover();
    t_hpd();
    t_modes();
    t_restore();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule